// File: doc/BRIEF.md
# Host Port Initialize Command and DMA Byte Sequencer

This block is the control core of a byte-wide parallel host port. It carries a self-clearing initialize command that puts the two transfer paths (host-to-DSP and DSP-to-host) into a known handshake state. Which paths are touched depends on a pair of request enables. The same command also preloads a two-bit byte-address counter.

During DMA transfers the counter walks the host through the bytes of one data word, one step per acknowledge strobe. When the low byte is reached, the word ends: the counter reloads from the mode bits and a one-cycle done pulse is raised. The mode bits pick the word size. Value 01 means 24-bit words starting at the high byte. Value 10 means 16-bit words starting at the middle byte. Value 11 means 8-bit words at the low byte. Value 00 selects interrupt mode, in which acknowledge strobes are ignored.

Two data strobes mark a word written into either path, so the empty and full flags can leave their idle values. The data registers, bus decoding and interrupt vector logic sit outside this block.

Top module: `hport_init_seq`

## Requirements
- R1: After the asynchronous reset, or a cycle with `soft_rst_i` or `indiv_rst_i` high, the outputs are as follows. `init_o`=0, `h2d_empty_o`=1, `h2d_full_o`=0, `d2h_empty_o`=1, `d2h_full_o`=0, `dir_o`=00, `cnt_o`=00, `done_o`=0 and `err_o`=0.
- R2: The initialize bit behaves as follows.
  - A one-cycle `init_set_i` pulse makes `init_o` high for exactly the next cycle.
  - On the edge that ends that cycle, the command executes and the bit clears itself.
  - A pulse while the bit is already high is ignored.
  - `stop_i`, or either synchronous reset, in the cycle the bit is high clears it and cancels execution. All flags and the counter are then kept, except under a reset.
- R3: Execution always loads `cnt_o` with `mode_i`. In interrupt mode (`mode_i`=00) this gives 00. This holds for every request-enable combination.
- R4: Execution acts on the flags and direction according to the request enables.
  - `rreq_i` set: `d2h_full_o`=0 and `d2h_empty_o`=1.
  - `treq_i` set: `h2d_empty_o`=1 and `h2d_full_o`=0.
  - `dir_o` encodes the selected paths as 00 none, 01 DSP-to-host, 10 host-to-DSP, 11 both.
  - With neither enable set, the flags are untouched and `dir_o` becomes 00.
- R5: Execution with both enables set and `mode_i`≠00 is illegal. `err_o` pulses for one cycle, the four flags and `dir_o` keep their values, and the counter is still loaded from `mode_i`.
- R6: In DMA mode, an accepted `dma_ack_i` behaves as follows.
  - Below 11, it increments `cnt_o`.
  - At 11, it reloads `cnt_o` from `mode_i` and makes `done_o` high for the one following cycle.
  - Only an access at 11 raises `done_o`.
- R7: In interrupt mode, `dma_ack_i` changes neither `cnt_o` nor `done_o`.
- R8: `dma_ack_i` is ignored in a cycle with `init_set_i` high and in the cycle the command executes. The initialize command has priority.
- R9: `h2d_wr_i` sets `h2d_empty_o`=0 and `h2d_full_o`=1, and `d2h_wr_i` does the same for the DSP-to-host flags. Execution overrides a strobe in the same cycle for every path it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset |
| indiv_rst_i | input | 1 | Synchronous reset of this port only |
| stop_i | input | 1 | Stop condition, clears a pending command |
| init_set_i | input | 1 | Write of 1 to the initialize bit |
| treq_i | input | 1 | Host-to-DSP request enable |
| rreq_i | input | 1 | DSP-to-host request enable |
| mode_i | input | 2 | 00 interrupt mode, else DMA word start byte |
| dma_ack_i | input | 1 | DMA acknowledge strobe, one per byte |
| h2d_wr_i | input | 1 | Host wrote a word into the host-to-DSP path |
| d2h_wr_i | input | 1 | DSP wrote a word into the DSP-to-host path |
| init_o | output | 1 | Initialize bit pending |
| h2d_empty_o | output | 1 | Host-to-DSP path may accept a word |
| h2d_full_o | output | 1 | Host-to-DSP path holds a word |
| d2h_empty_o | output | 1 | DSP-to-host path may accept a word |
| d2h_full_o | output | 1 | DSP-to-host path holds a word |
| dir_o | output | 2 | Selected transfer direction |
| cnt_o | output | 2 | Byte-address counter |
| done_o | output | 1 | One-cycle pulse after a completed DMA word |
| err_o | output | 1 | One-cycle pulse on an illegal initialize |

## Verification
The initialize command and a DMA acknowledge can land on the same edge. So can the command and a data strobe.

The bench provokes the first case by raising `dma_ack_i` with `init_set_i` and holding it through the execution cycle, with the counter parked at 11. It is judged correct only if the counter lands on the mode value and `done_o` never rises. The second case is provoked by a host-to-DSP strobe in the execution cycle of a transmit-enabled command, and the flags must show the idle pair.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int unsigned CNT_W = 2;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_D2H  = 2'b01,
    DIR_H2D  = 2'b10,
    DIR_BOTH = 2'b11
  } dir_e;
endpackage

// File: rtl/hport_cmd.sv
module hport_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic stop_i,
  input  logic set_i,
  output logic init_o,
  output logic exec_o
);
  logic init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              init_q <= 1'b0;
    else if (srst_i || stop_i) init_q <= 1'b0;
    else if (init_q)          init_q <= 1'b0;  // self-clear on execution
    else                      init_q <= set_i;
  end

  assign init_o = init_q;
  assign exec_o = init_q && !srst_i && !stop_i;

  a_r2_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> !init_q);
  a_r2_stop_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !init_q);
endmodule

// File: rtl/hport_flags.sv
module hport_flags
  import hport_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic exec_i,
  input  logic treq_i,
  input  logic rreq_i,
  input  logic dma_mode_i,
  input  logic h2d_wr_i,
  input  logic d2h_wr_i,
  output logic h2d_empty_o,
  output logic h2d_full_o,
  output logic d2h_empty_o,
  output logic d2h_full_o,
  output dir_e dir_o,
  output logic err_o
);
  logic h2d_empty_q, h2d_full_q, d2h_empty_q, d2h_full_q, err_q;
  dir_e dir_q;
  logic illegal;

  assign illegal = treq_i && rreq_i && dma_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h2d_empty_q <= 1'b1;
      h2d_full_q  <= 1'b0;
      d2h_empty_q <= 1'b1;
      d2h_full_q  <= 1'b0;
      dir_q       <= DIR_NONE;
      err_q       <= 1'b0;
    end else if (srst_i) begin
      h2d_empty_q <= 1'b1;
      h2d_full_q  <= 1'b0;
      d2h_empty_q <= 1'b1;
      d2h_full_q  <= 1'b0;
      dir_q       <= DIR_NONE;
      err_q       <= 1'b0;
    end else begin
      err_q <= exec_i && illegal;
      if (!(exec_i && illegal)) begin
        if (h2d_wr_i) begin
          h2d_empty_q <= 1'b0;
          h2d_full_q  <= 1'b1;
        end
        if (d2h_wr_i) begin
          d2h_empty_q <= 1'b0;
          d2h_full_q  <= 1'b1;
        end
      end
      if (exec_i && !illegal) begin
        dir_q <= dir_e'({treq_i, rreq_i});
        if (treq_i) begin
          h2d_empty_q <= 1'b1;
          h2d_full_q  <= 1'b0;
        end
        if (rreq_i) begin
          d2h_empty_q <= 1'b1;
          d2h_full_q  <= 1'b0;
        end
      end
    end
  end

  assign h2d_empty_o = h2d_empty_q;
  assign h2d_full_o  = h2d_full_q;
  assign d2h_empty_o = d2h_empty_q;
  assign d2h_full_o  = d2h_full_q;
  assign dir_o       = dir_q;
  assign err_o       = err_q;

  a_r5_illegal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && illegal && !srst_i) |=>
      (err_q && $stable(h2d_empty_q) && $stable(h2d_full_q) &&
       $stable(d2h_empty_q) && $stable(d2h_full_q) && $stable(dir_q)));
  a_r4_h2d_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && treq_i && !illegal && !srst_i) |=> (h2d_empty_q && !h2d_full_q));
  a_r4_d2h_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && rreq_i && !illegal && !srst_i) |=> (d2h_empty_q && !d2h_full_q));
  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2d_empty_q != h2d_full_q) && (d2h_empty_q != d2h_full_q));
endmodule

// File: rtl/hport_bytecnt.sv
module hport_bytecnt #(
  parameter int unsigned CNT_W = hport_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             exec_i,
  input  logic             blk_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             dma_mode, acc, last;

  assign dma_mode = |mode_i;
  assign acc      = ack_i && dma_mode && !blk_i && !exec_i;
  assign last     = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (srst_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= acc && last;
      if (exec_i)        cnt_q <= mode_i;
      else if (acc)      cnt_q <= last ? mode_i : cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !srst_i) |=> (cnt_q == $past(mode_i)));
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !last && !srst_i) |=> (cnt_q == $past(cnt_q) + 1'b1) && !done_q);
  a_r6_done_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(cnt_q) == CNT_LAST));
  a_r7_imode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !dma_mode && !exec_i && !srst_i) |=> ($stable(cnt_q) && !done_q));
endmodule

// File: rtl/hport_init_seq.sv
module hport_init_seq
  import hport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       indiv_rst_i,
  input  logic       stop_i,
  input  logic       init_set_i,
  input  logic       treq_i,
  input  logic       rreq_i,
  input  logic [1:0] mode_i,
  input  logic       dma_ack_i,
  input  logic       h2d_wr_i,
  input  logic       d2h_wr_i,
  output logic       init_o,
  output logic       h2d_empty_o,
  output logic       h2d_full_o,
  output logic       d2h_empty_o,
  output logic       d2h_full_o,
  output logic [1:0] dir_o,
  output logic [1:0] cnt_o,
  output logic       done_o,
  output logic       err_o
);
  logic srst, exec;
  dir_e dir;

  assign srst = soft_rst_i || indiv_rst_i;

  hport_cmd u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .stop_i (stop_i),
    .set_i  (init_set_i),
    .init_o (init_o),
    .exec_o (exec)
  );

  hport_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst),
    .exec_i      (exec),
    .treq_i      (treq_i),
    .rreq_i      (rreq_i),
    .dma_mode_i  (|mode_i),
    .h2d_wr_i    (h2d_wr_i),
    .d2h_wr_i    (d2h_wr_i),
    .h2d_empty_o (h2d_empty_o),
    .h2d_full_o  (h2d_full_o),
    .d2h_empty_o (d2h_empty_o),
    .d2h_full_o  (d2h_full_o),
    .dir_o       (dir),
    .err_o       (err_o)
  );

  assign dir_o = dir;

  hport_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .exec_i (exec),
    .blk_i  (init_set_i),
    .ack_i  (dma_ack_i),
    .mode_i (mode_i),
    .cnt_o  (cnt_o),
    .done_o (done_o)
  );

  // R8: acknowledge in the write cycle must not move the counter
  a_r8_ack_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_set_i && !init_o && dma_ack_i && !srst) |=> ($stable(cnt_o) && !done_o));
  a_r1_srst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (!init_o && cnt_o == 2'b00 && h2d_empty_o && d2h_empty_o && !err_o));
endmodule

// File: tb/sim_hport_init_seq.sv
module sim_hport_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, indiv_rst = 0, stop = 0, init_set = 0;
  logic treq = 0, rreq = 0, ack = 0, h2d_wr = 0, d2h_wr = 0;
  logic [1:0] mode = 2'b00;
  logic init, h2d_e, h2d_f, d2h_e, d2h_f, done, err;
  logic [1:0] dir, cnt;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  hport_init_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .indiv_rst_i(indiv_rst),
    .stop_i(stop), .init_set_i(init_set), .treq_i(treq), .rreq_i(rreq),
    .mode_i(mode), .dma_ack_i(ack), .h2d_wr_i(h2d_wr), .d2h_wr_i(d2h_wr),
    .init_o(init), .h2d_empty_o(h2d_e), .h2d_full_o(h2d_f), .d2h_empty_o(d2h_e),
    .d2h_full_o(d2h_f), .dir_o(dir), .cnt_o(cnt), .done_o(done), .err_o(err)
  );

  // {treq, rreq, mode} | flags {h2d_e,h2d_f,d2h_e,d2h_f} | dir | cnt | err
  // start state before each: both paths holding a word (0101), dir 00
  localparam logic [12:0] VEC [16] = '{
    13'b0000_0101_00_00_0, 13'b0001_0101_00_01_0,
    13'b0010_0101_00_10_0, 13'b0011_0101_00_11_0,
    13'b0100_0110_01_00_0, 13'b0101_0110_01_01_0,
    13'b0110_0110_01_10_0, 13'b0111_0110_01_11_0,
    13'b1000_1001_10_00_0, 13'b1001_1001_10_01_0,
    13'b1010_1001_10_10_0, 13'b1011_1001_10_11_0,
    13'b1100_1010_11_00_0, 13'b1101_0101_00_01_1,
    13'b1110_0101_00_10_1, 13'b1111_0101_00_11_1
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic prime();
    soft_rst = 1; cyc(); soft_rst = 0;
    h2d_wr = 1; d2h_wr = 1; cyc(); h2d_wr = 0; d2h_wr = 0;
  endtask

  task automatic do_init(input logic t, input logic r, input logic [1:0] m);
    treq = t; rreq = r; mode = m; init_set = 1;
    cyc(); init_set = 0;
    chk({7'd0, init}, 8'd1, "R2 init pending");
    cyc();
    chk({7'd0, init}, 8'd0, "R2 init self-cleared");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] e;
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk({init, h2d_e, h2d_f, d2h_e, d2h_f, done, err, 1'b0}, 8'b0101_0000, "R1 reset flags");
    chk({4'd0, dir, cnt}, 8'd0, "R1 reset dir/cnt");

    // R3 R4 R5 table of every enable/mode combination
    for (int i = 0; i < 16; i++) begin
      prime();
      do_init(VEC[i][12], VEC[i][11], VEC[i][10:9]);
      chk({4'd0, h2d_e, h2d_f, d2h_e, d2h_f}, {4'd0, VEC[i][8:5]}, $sformatf("R4 flags v%0d", i));
      chk({6'd0, dir}, {6'd0, VEC[i][4:3]}, $sformatf("R4 dir v%0d", i));
      chk({6'd0, cnt}, {6'd0, VEC[i][2:1]}, $sformatf("R3 cnt v%0d", i));
      chk({7'd0, err}, {7'd0, VEC[i][0]}, $sformatf("R5 err v%0d", i));
      cyc();
      chk({7'd0, err}, 8'd0, $sformatf("R5 err one cycle v%0d", i));
    end

    // R6 DMA word sequences, three words per size
    for (int m = 1; m < 4; m++) begin
      prime();
      do_init(1'b1, 1'b0, 2'(m));
      e = 2'(m);
      for (int k = 0; k < 3 * (4 - m); k++) begin
        logic expd;
        ack = 1; cyc(); ack = 0;
        expd = (e == 2'b11);
        e = expd ? 2'(m) : e + 2'd1;
        chk({6'd0, cnt}, {6'd0, e}, $sformatf("R6 cnt m%0d k%0d", m, k));
        chk({7'd0, done}, {7'd0, expd}, $sformatf("R6 done m%0d k%0d", m, k));
        cyc();
        chk({7'd0, done}, 8'd0, $sformatf("R6 done drop m%0d k%0d", m, k));
      end
    end

    // R7 interrupt mode ignores acknowledge
    prime();
    do_init(1'b0, 1'b1, 2'b00);
    ack = 1; cyc(); cyc(); ack = 0;
    chk({6'd0, cnt, done}, 8'd0, "R7 cnt/done held");

    // R8 init beats acknowledge, counter parked at 11
    prime();
    do_init(1'b1, 1'b0, 2'b10);
    ack = 1; cyc();
    chk({6'd0, cnt}, 8'd3, "R8 setup cnt");
    init_set = 1; cyc(); init_set = 0;
    chk({5'd0, cnt, done}, 8'b110, "R8 write-cycle ack ignored");
    cyc(); ack = 0;
    chk({5'd0, cnt, done}, 8'b100, "R8 exec-cycle ack ignored");

    // R9 data strobes and exec override
    prime();
    chk({4'd0, h2d_e, h2d_f, d2h_e, d2h_f}, 8'b0101, "R9 strobes set full");
    treq = 1; rreq = 0; mode = 2'b00; init_set = 1; cyc(); init_set = 0;
    h2d_wr = 1; cyc(); h2d_wr = 0;
    chk({4'd0, h2d_e, h2d_f, d2h_e, d2h_f}, 8'b1001, "R9 exec overrides strobe");

    // R2 stop cancels a pending command
    prime();
    treq = 1; rreq = 1; mode = 2'b01; init_set = 1; cyc(); init_set = 0;
    stop = 1; cyc(); stop = 0;
    chk({init, h2d_e, h2d_f, d2h_e, d2h_f, 3'd0}, 8'b0010_1000, "R2 stop cancels");
    chk({6'd0, cnt}, 8'd0, "R2 stop keeps cnt");

    // R2 write while pending ignored
    treq = 0; rreq = 0; init_set = 1; cyc(); cyc(); init_set = 0;
    chk({7'd0, init}, 8'd0, "R2 second write ignored");

    // R1 individual reset mid-word
    do_init(1'b1, 1'b0, 2'b01);
    ack = 1; cyc(); ack = 0;
    indiv_rst = 1; cyc(); indiv_rst = 0;
    chk({init, h2d_e, h2d_f, d2h_e, d2h_f, done, err, 1'b0}, 8'b0101_0000, "R1 indiv reset flags");
    chk({4'd0, dir, cnt}, 8'd0, "R1 indiv reset dir/cnt");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule